// File: doc/BRIEF.md
# Serial Port Status and Interrupt Controller

This block holds the status flags, interrupt enables and DMA request logic of a serial peripheral. Software reaches it over a simple register bus with four word addresses. A shift engine outside the block reports its events as single-cycle strobes, and it also supplies two levels: busy and channel side. The block merges each flag with its enable bit to drive one interrupt line. It raises a transmit and a receive DMA request when the matching enable is set.

Each of the four error flags leaves by its own route:

- Overrun clears when a data read is followed later by a status read.
- Mode fault clears when a status read or write is followed later by a control-1 write.
- Underrun and frame error clear on any status read.
- The CRC error clears when software writes a zero to its status bit.

If a new error arrives in the same cycle as the access that would clear it, the error wins.

Top module: `spi_stat_irq`

## Requirements
- R1: After reset, status reads 0x001 (only transmit-empty set), control 2 reads 0, and irq, dma_tx_req and dma_rx_req are low.
- R2: Transmit-empty (status bit 0) clears on a write to the data address (3) and sets on ev_load. The written word appears on tx_word.
- R3: Receive-not-empty (status bit 1) sets on ev_rx and clears on a data read. If ev_rx arrives while the flag is already set, overrun (bit 5) sets and the stored word is kept.
- R4: Overrun clears only on a status read (address 2) that comes after a data read made while overrun was set. A status read before that data read, or either access alone, leaves it set.
- R5: Mode fault (bit 4) clears only on a control-1 write (address 0) that comes after a status read or write made while the flag was set. A control-1 write alone leaves it set.
- R6: Underrun (bit 7) and frame error (bit 6) clear on any status read.
- R7: CRC error (bit 3) clears when a status write has 0 in bit 3. A 1 in that bit leaves it set. A status write changes no other flag.
- R8: An error event in the same cycle as its clearing access leaves the flag set. ev_load in the same cycle as a data write leaves transmit-empty set.
- R9: Control 2 (address 1) holds the interrupt enables: bit 0 for transmit-empty, bit 1 for receive-not-empty, bit 2 for errors. irq is the OR of each flag ANDed with its enable. Bit 2 covers CRC error, mode fault, overrun, frame error and underrun together.
- R10: Control 2 bit 3 gates dma_tx_req from transmit-empty. Control 2 bit 4 gates dma_rx_req from receive-not-empty.
- R11: Busy (bit 2) and channel side (bit 8) follow eng_busy and eng_side and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | Word address: 0 control 1, 1 control 2, 2 status, 3 data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data (combinational) |
| ctrl_word | output | DW | Control 1 contents for the engine |
| tx_word | output | DW | Last word written to data |
| ev_load | input | 1 | Engine took the transmit word |
| ev_rx | input | 1 | Engine delivers a received word |
| rx_word | input | DW | Received word |
| ev_crc_err | input | 1 | CRC mismatch event |
| ev_mode_fault | input | 1 | Mode fault event |
| ev_frame_err | input | 1 | Frame format error event |
| ev_underrun | input | 1 | Underrun event |
| eng_busy | input | 1 | Engine busy level |
| eng_side | input | 1 | Channel side level |
| irq | output | 1 | Interrupt request |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
Each sequence tracker is one bit, and a wrong value shows up on the second access of its pair. With the error enable set, irq stays high or drops one cycle too early, and the next status read returns the flag in the wrong state. A lost or corrupted receive word shows in the data read that follows the overrun. A wrong enable bit shows at once on irq or the DMA lines, one cycle after the control 2 write.

// File: rtl/spi_stat_irq.sv
module spi_stat_irq #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] ctrl_word,
  output logic [DW-1:0] tx_word,
  input  logic          ev_load,
  input  logic          ev_rx,
  input  logic [DW-1:0] rx_word,
  input  logic          ev_crc_err,
  input  logic          ev_mode_fault,
  input  logic          ev_frame_err,
  input  logic          ev_underrun,
  input  logic          eng_busy,
  input  logic          eng_side,
  output logic          irq,
  output logic          dma_tx_req,
  output logic          dma_rx_req
);
  localparam logic [1:0] A_CTL1 = 2'd0, A_CTL2 = 2'd1, A_STAT = 2'd2, A_DATA = 2'd3;
  localparam int SW = 9;
  localparam int CW = 5;
  localparam int CRC_BIT = 3;

  logic wr_c1, wr_c2, wr_st, wr_dat, rd_st, rd_dat;
  assign wr_c1  = bus_wr && bus_addr == A_CTL1;
  assign wr_c2  = bus_wr && bus_addr == A_CTL2;
  assign wr_st  = bus_wr && bus_addr == A_STAT;
  assign wr_dat = bus_wr && bus_addr == A_DATA;
  assign rd_st  = bus_rd && bus_addr == A_STAT;
  assign rd_dat = bus_rd && bus_addr == A_DATA;

  logic [DW-1:0] ctl1_q, tx_q, rx_q;
  logic [CW-1:0] ctl2_q;
  logic txe_q, rxne_q, crc_q, modf_q, ovr_q, fre_q, udr_q;
  logic ovr_arm, modf_arm;

  logic ovr_set, ovr_clr, modf_clr, crc_clr;
  assign ovr_set  = ev_rx && rxne_q;
  assign ovr_clr  = rd_st && ovr_arm;
  assign modf_clr = wr_c1 && modf_arm;
  assign crc_clr  = wr_st && !bus_wdata[CRC_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1_q   <= '0;
      ctl2_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      txe_q    <= 1'b1;
      rxne_q   <= 1'b0;
      crc_q    <= 1'b0;
      modf_q   <= 1'b0;
      ovr_q    <= 1'b0;
      fre_q    <= 1'b0;
      udr_q    <= 1'b0;
      ovr_arm  <= 1'b0;
      modf_arm <= 1'b0;
    end else begin
      if (wr_c1) ctl1_q <= bus_wdata;
      if (wr_c2) ctl2_q <= bus_wdata[CW-1:0];
      if (wr_dat) tx_q <= bus_wdata;
      if (ev_rx && !rxne_q) rx_q <= rx_word;

      txe_q  <= ev_load ? 1'b1 : (wr_dat ? 1'b0 : txe_q);
      rxne_q <= ev_rx ? 1'b1 : (rd_dat ? 1'b0 : rxne_q);

      crc_q  <= ev_crc_err    ? 1'b1 : (crc_clr  ? 1'b0 : crc_q);
      modf_q <= ev_mode_fault ? 1'b1 : (modf_clr ? 1'b0 : modf_q);
      ovr_q  <= ovr_set       ? 1'b1 : (ovr_clr  ? 1'b0 : ovr_q);
      fre_q  <= ev_frame_err  ? 1'b1 : (rd_st    ? 1'b0 : fre_q);
      udr_q  <= ev_underrun   ? 1'b1 : (rd_st    ? 1'b0 : udr_q);

      ovr_arm  <= (ovr_q && !ovr_clr)   ? (ovr_arm || rd_dat) : 1'b0;
      modf_arm <= (modf_q && !modf_clr) ? (modf_arm || rd_st || wr_st) : 1'b0;
    end
  end

  logic [SW-1:0] stat;
  assign stat = {eng_side, udr_q, fre_q, ovr_q, modf_q, crc_q, eng_busy, rxne_q, txe_q};

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTL1:  bus_rdata = ctl1_q;
        A_CTL2:  bus_rdata[CW-1:0] = ctl2_q;
        A_STAT:  bus_rdata[SW-1:0] = stat;
        default: bus_rdata = rx_q;
      endcase
    end
  end

  logic ie_txe, ie_rxne, ie_err, den_tx, den_rx, any_err;
  assign {den_rx, den_tx, ie_err, ie_rxne, ie_txe} = ctl2_q;
  assign any_err    = crc_q | modf_q | ovr_q | fre_q | udr_q;
  assign irq        = (txe_q & ie_txe) | (rxne_q & ie_rxne) | (any_err & ie_err);
  assign dma_tx_req = txe_q & den_tx;
  assign dma_rx_req = rxne_q & den_rx;
  assign ctrl_word  = ctl1_q;
  assign tx_word    = tx_q;

  // R4
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_arm) |=> ovr_q);
  // R5
  modf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modf_q && !modf_arm) |=> modf_q);
  // R6
  udr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_q && rd_st && !ev_underrun) |=> !udr_q);
  // R7
  crc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_q && !(bus_wr && bus_addr == A_STAT)) |=> crc_q);
  // R3
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx && rxne_q) |=> ($stable(rx_q) && ovr_q));
  // R8
  crc_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_crc_err |=> crc_q);
  // R2
  txe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> txe_q);
  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl2_q[2:0] == 3'b000) |-> !irq);
  // R10
  dma_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> rxne_q);
endmodule

// File: tb/spi_stat_irq_tb.sv
module spi_stat_irq_tb;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata, ctrl_word, tx_word, rx_word = '0;
  logic ev_load = 0, ev_rx = 0, ev_crc_err = 0, ev_mode_fault = 0, ev_frame_err = 0, ev_underrun = 0;
  logic eng_busy = 0, eng_side = 0, irq, dma_tx_req, dma_rx_req;
  int checks = 0, errors = 0;
  logic done = 0;

  always #4 clk = ~clk;

  spi_stat_irq #(.DW(DW)) u_dut (.*);

  localparam logic [3:0] RDS = 0, RDD = 1, WRD = 2, WRS = 3, WR1 = 4, WR2 = 5, RX = 6, LOAD = 7, ERR = 8;
  localparam int NV = 27;
  localparam logic [35:0] VEC [NV] = '{
    {RDS, 16'h0000, 16'h0001}, {WR2, 16'h0009, 16'h0006}, {WRD, 16'hA5A5, 16'h0000},
    {LOAD,16'h0000, 16'h0006}, {WR2, 16'h0012, 16'h0000}, {RX,  16'h1234, 16'h0005},
    {RX,  16'h5678, 16'h0005}, {RDS, 16'h0000, 16'h0023}, {RDD, 16'h0000, 16'h1234},
    {WR2, 16'h0004, 16'h0004}, {RDS, 16'h0000, 16'h0021}, {WR1, 16'h0000, 16'h0000},
    {RDS, 16'h0000, 16'h0001}, {ERR, 16'h0002, 16'h0004}, {WR1, 16'h0000, 16'h0004},
    {WRS, 16'hFFFF, 16'h0004}, {WR1, 16'h0000, 16'h0000}, {RDS, 16'h0000, 16'h0001},
    {ERR, 16'h0001, 16'h0004}, {WRS, 16'hFFFF, 16'h0004}, {WRS, 16'hFFF7, 16'h0000},
    {ERR, 16'h0008, 16'h0004}, {RDS, 16'h0000, 16'h0081}, {WR2, 16'h0004, 16'h0000},
    {ERR, 16'h0004, 16'h0004}, {RDS, 16'h0000, 16'h0041}, {WR2, 16'h0004, 16'h0000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    bus_wr = 0; bus_rd = 0; ev_load = 0; ev_rx = 0;
    ev_crc_err = 0; ev_mode_fault = 0; ev_frame_err = 0; ev_underrun = 0;
  endtask

  task automatic apply(input logic [3:0] op, input logic [15:0] arg, output logic [15:0] rv);
    case (op)
      RDS:  begin bus_rd = 1; bus_addr = 2; end
      RDD:  begin bus_rd = 1; bus_addr = 3; end
      WRD:  begin bus_wr = 1; bus_addr = 3; bus_wdata = arg; end
      WRS:  begin bus_wr = 1; bus_addr = 2; bus_wdata = arg; end
      WR1:  begin bus_wr = 1; bus_addr = 0; bus_wdata = arg; end
      WR2:  begin bus_wr = 1; bus_addr = 1; bus_wdata = arg; end
      RX:   begin ev_rx = 1; rx_word = arg; end
      LOAD: ev_load = 1;
      default: {ev_underrun, ev_frame_err, ev_mode_fault, ev_crc_err} = arg[3:0];
    endcase
    #2 rv = bus_rdata;
    @(posedge clk);
    @(negedge clk);
    clear_in();
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", {13'b0, irq, dma_tx_req, dma_rx_req}, 16'h0000);
    apply(RDS, 0, rv); check("R1 status", rv, 16'h0001);
    bus_rd = 1; bus_addr = 1; #2 check("R1 ctrl2", bus_rdata, 16'h0000);
    @(negedge clk); clear_in();

    // R2 R3 R4 R5 R6 R7 R9 R10 sequence table
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      op = VEC[i][35:32];
      apply(op, VEC[i][31:16], rv);
      if (op == RDS || op == RDD)
        check($sformatf("R3-R7 vec %0d read", i), rv, VEC[i][15:0]);
      else
        check($sformatf("R9 R10 vec %0d outputs", i), {13'b0, irq, dma_tx_req, dma_rx_req}, VEC[i][15:0]);
    end

    // R2 transmit word
    check("R2 tx_word", tx_word, 16'hA5A5);

    // R11 pass-through
    eng_busy = 1; eng_side = 1;
    apply(RDS, 0, rv); check("R11 busy side", rv, 16'h0105);
    apply(WRS, 16'h0000, rv);
    apply(RDS, 0, rv); check("R11 not writable", rv, 16'h0105);
    eng_busy = 0; eng_side = 0;

    // R8 set beats clear
    bus_wr = 1; bus_addr = 2; bus_wdata = 16'h0000; ev_crc_err = 1;
    @(posedge clk); @(negedge clk); clear_in();
    apply(RDS, 0, rv); check("R8 crc priority", rv, 16'h0009);
    apply(WRS, 16'h0000, rv);
    bus_wr = 1; bus_addr = 3; bus_wdata = 16'h3C3C; ev_load = 1;
    @(posedge clk); @(negedge clk); clear_in();
    apply(RDS, 0, rv); check("R8 txe priority", rv, 16'h0001);

    // R4 data read alone then control writes leave overrun
    apply(RX, 16'h1111, rv); apply(RX, 16'h2222, rv);
    apply(RDD, 0, rv); check("R3 kept word", rv, 16'h1111);
    apply(WR1, 0, rv); apply(WRS, 16'hFFFF, rv);
    apply(RDS, 0, rv); check("R4 clear after data read", rv, 16'h0021);
    apply(RDS, 0, rv); check("R4 cleared", rv, 16'h0001);

    // R1 ctrl1 storage
    apply(WR1, 16'h5A0F, rv);
    check("R1 ctrl_word", ctrl_word, 16'h5A0F);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule